// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside a small processor core and turns event strobes into a single interrupt request with a vector address. Three core sources each have their own vector: an external pin edge, a timer overflow and a second counter-pin edge. A bank of peripheral sources shares one fourth vector through a summary flag. Every source has a latched flag and an enable. One global disable bit gates all requests.

When the core accepts a request by pulsing `ack`, the block sets the global disable bit and emits a one-cycle push strobe. If the accepted source is a core source, its flag clears in hardware. Peripheral flags stay set until software clears them at the individual source. A return strobe clears the global disable bit again. The wake output reports any enabled pending source, whatever the state of the global disable bit.

Top module: `irq_vector_ctl`

## Requirements
- R1: After a synchronous reset all flags, `gdis`, `irq_req`, `vec_addr`, `push_stb`, `per_summary` and `wake` are zero.
- R2: A source event sets its flag on the clock edge that samples it, whatever its enable bit and `gdis` hold. Core flag bit 0 is the external pin, bit 1 is the timer and bit 2 is the counter pin.
- R3: Each pin source detects edges by comparing against the pin level at the previous edge. When its rise select is 1, only a 0-to-1 change sets the flag. When its rise select is 0, only a 1-to-0 change sets it.
- R4: On the clock edge after an enabled flag is visible, while `gdis` is 0, `irq_req` goes high. At the same time `vec_addr` shows 08h for the external pin, 10h for the timer, 18h for the counter pin and 20h for the peripheral group. With no request, `vec_addr` is 0 and a flag with its enable low never requests.
- R5: With several requests pending, the winner is the external pin first, then the timer, then the counter pin, then the peripheral group.
- R6: An `ack` while `irq_req` is high has four effects on the next edge: `irq_req` drops, `gdis` sets, `push_stb` pulses for one cycle and the accepted core flag clears. An `ack` with no request has no effect.
- R7: `per_summary` is the OR over peripheral sources of flag AND enable, gated by `per_grp_en`. Accepting the peripheral vector leaves peripheral flags set, and `per_clr` bits clear them.
- R8: `reti` clears `gdis`, and a still-pending enabled flag requests again one edge later.
- R9: `wake` goes high one edge after any enabled flag (or the gated summary) is pending, even while `gdis` is 1.
- R10: A software write to the core flags loads `flag_wr_val`, so a 1 forces an interrupt and a 0 clears. An event in the same cycle wins over a clearing write.
- R11: A software write sets or clears `gdis`, and while `gdis` is 1 no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | External interrupt pin level |
| ext_rise | input | 1 | 1: rising edge on ext_pin, 0: falling |
| cnt_pin | input | 1 | Counter pin level |
| cnt_rise | input | 1 | 1: rising edge on cnt_pin, 0: falling |
| tmr_ovf | input | 1 | Timer overflow strobe |
| per_evt | input | NPER | Peripheral event strobes |
| core_en | input | 3 | Enables of the three core sources |
| per_en | input | NPER | Per-source peripheral enables |
| per_grp_en | input | 1 | Peripheral group enable |
| flag_wr | input | 1 | Software write strobe for core flags |
| flag_wr_val | input | 3 | Value written to core flags |
| per_clr | input | NPER | Clear strobes for peripheral flags |
| gdis_wr | input | 1 | Software write strobe for global disable |
| gdis_val | input | 1 | Value written to global disable |
| reti | input | 1 | Return-from-interrupt strobe |
| ack | input | 1 | Core accepts the current vector |
| irq_req | output | 1 | Interrupt request to the core |
| vec_addr | output | VEC_W | Vector address of the request |
| push_stb | output | 1 | Return-address push strobe |
| core_flags | output | 3 | Core source flags |
| per_flags | output | NPER | Peripheral source flags |
| per_summary | output | 1 | Gated peripheral summary flag |
| gdis | output | 1 | Global disable bit |
| wake | output | 1 | Wake-up indication |

## Verification
A table of rows drives single forced sources, combinations of two or three sources, sources with their enable or group enable low, and peripheral events mixed with core ones. Each row separates the vector encoding from the priority order and from enable gating. Directed sequences then walk the accept, push and return cycle for both a core source and the peripheral group. This shows whether a flag clears in hardware or stays set. Pin-edge polarity is tried in both directions on both pins. A clearing write racing an event, wake-up under global disable and an acknowledge without a request each get their own check.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NCORE = 3;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;
  localparam int SRC_CNT = 2;
  localparam int SRC_PER = 3;
endpackage

// File: rtl/irqv_edge_det.sv
module irqv_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] rise_sel,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk) begin
      prev_q[i] <= pin[i];
    end
    // rising: low before, high now; falling: the reverse
    assign edge_o[i] = (rst == 1'b0) &&
                       (rise_sel[i] ? (pin[i] & ~prev_q[i]) : (~pin[i] & prev_q[i]));
  end
endmodule

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
  parameter int NC = 3,
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] core_evt,
  input  logic          wr_en,
  input  logic [NC-1:0] wr_val,
  input  logic [NC-1:0] hw_clr,
  input  logic [NP-1:0] per_evt,
  input  logic [NP-1:0] per_clr,
  output logic [NC-1:0] core_flag,
  output logic [NP-1:0] per_flag
);
  for (genvar i = 0; i < NC; i++) begin : g_core
    always_ff @(posedge clk) begin
      if (rst)               core_flag[i] <= 1'b0;
      else if (core_evt[i])  core_flag[i] <= 1'b1;
      else if (wr_en)        core_flag[i] <= wr_val[i];
      else if (hw_clr[i])    core_flag[i] <= 1'b0;
    end
    // R2: an event always leaves its flag set
    p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
      core_evt[i] |=> core_flag[i]);
  end

  for (genvar j = 0; j < NP; j++) begin : g_per
    always_ff @(posedge clk) begin
      if (rst)              per_flag[j] <= 1'b0;
      else if (per_evt[j])  per_flag[j] <= 1'b1;
      else if (per_clr[j])  per_flag[j] <= 1'b0;
    end
    // R7: only an explicit clear removes a peripheral flag
    p_per_flag_kept_r7: assert property (@(posedge clk) disable iff (rst)
      (per_flag[j] && !per_clr[j]) |=> per_flag[j]);
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int             NS       = 4,
  parameter int             VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h08,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h08
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NS-1:0]    pend,
  input  logic             blocked,
  input  logic             take,
  output logic [NS-1:0]    sel_q,
  output logic [VEC_W-1:0] vec_q,
  output logic             irq
);
  logic [NS-1:0]    grant;
  logic [VEC_W-1:0] vec_d;

  // lowest index wins
  assign grant = pend & (~pend + NS'(1));

  always_comb begin
    vec_d = '0;
    for (int i = 0; i < NS; i++) begin
      if (grant[i]) vec_d = VEC_W'(int'(VEC_BASE) + i * int'(VEC_STEP));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || blocked || take) begin
      sel_q <= '0;
      vec_q <= '0;
    end else begin
      sel_q <= grant;
      vec_q <= vec_d;
    end
  end

  assign irq = |sel_q;

  // R5: at most one source is selected
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
  // R11: a blocked cycle yields no request next
  p_blocked_no_irq_r11: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !irq);
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irqv_pkg::*;
#(
  parameter int NPER  = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             ext_rise,
  input  logic             cnt_pin,
  input  logic             cnt_rise,
  input  logic             tmr_ovf,
  input  logic [NPER-1:0]  per_evt,
  input  logic [2:0]       core_en,
  input  logic [NPER-1:0]  per_en,
  input  logic             per_grp_en,
  input  logic             flag_wr,
  input  logic [2:0]       flag_wr_val,
  input  logic [NPER-1:0]  per_clr,
  input  logic             gdis_wr,
  input  logic             gdis_val,
  input  logic             reti,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] vec_addr,
  output logic             push_stb,
  output logic [2:0]       core_flags,
  output logic [NPER-1:0]  per_flags,
  output logic             per_summary,
  output logic             gdis,
  output logic             wake
);
  localparam int NS = NCORE + 1;

  logic [1:0]       pin_edge;
  logic [NCORE-1:0] core_evt;
  logic [NCORE-1:0] hw_clr;
  logic [NS-1:0]    pend;
  logic [NS-1:0]    sel_q;
  logic             psum;
  logic             take;
  logic             gdis_q, push_q, wake_q, psum_q;

  irqv_edge_det #(.W(2)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin      ({cnt_pin, ext_pin}),
    .rise_sel ({cnt_rise, ext_rise}),
    .edge_o   (pin_edge)
  );

  assign core_evt[SRC_EXT] = pin_edge[0];
  assign core_evt[SRC_TMR] = tmr_ovf;
  assign core_evt[SRC_CNT] = pin_edge[1];

  assign take   = ack & irq_req;
  assign hw_clr = take ? sel_q[NCORE-1:0] : '0;

  irqv_flag_bank #(.NC(NCORE), .NP(NPER)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .core_evt  (core_evt),
    .wr_en     (flag_wr),
    .wr_val    (flag_wr_val),
    .hw_clr    (hw_clr),
    .per_evt   (per_evt),
    .per_clr   (per_clr),
    .core_flag (core_flags),
    .per_flag  (per_flags)
  );

  // flags and enables sampled together in one vector
  assign psum = per_grp_en & |(per_flags & per_en);
  assign pend = {psum, core_flags & core_en};

  irqv_arbiter #(
    .NS       (NS),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_W'(8'h08)),
    .VEC_STEP (VEC_W'(8'h08))
  ) u_arb (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .blocked (gdis_q),
    .take    (take),
    .sel_q   (sel_q),
    .vec_q   (vec_addr),
    .irq     (irq_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gdis_q <= 1'b0;
      push_q <= 1'b0;
      wake_q <= 1'b0;
      psum_q <= 1'b0;
    end else begin
      push_q <= take;
      wake_q <= |pend;
      psum_q <= psum;
      if (take)         gdis_q <= 1'b1;
      else if (reti)    gdis_q <= 1'b0;
      else if (gdis_wr) gdis_q <= gdis_val;
    end
  end

  assign gdis        = gdis_q;
  assign push_stb    = push_q;
  assign wake        = wake_q;
  assign per_summary = psum_q;

  // R6: acceptance drops the request, sets disable and pushes once
  p_take_drops_req_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_req) |=> (!irq_req && gdis && push_stb));
  p_push_single_r6: assert property (@(posedge clk) disable iff (rst)
    push_stb |=> !push_stb);
  // R8: return clears the disable bit
  p_reti_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (reti && !(ack && irq_req)) |=> !gdis);
endmodule

// File: tb/sim_irq_vector_ctl.sv
module sim_irq_vector_ctl;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int NROW = 12;

  logic clk = 1'b0;
  logic rst;
  logic ext_pin, ext_rise, cnt_pin, cnt_rise, tmr_ovf;
  logic [NP-1:0] per_evt, per_en, per_clr;
  logic [2:0] core_en, flag_wr_val;
  logic per_grp_en, flag_wr, gdis_wr, gdis_val, reti, ack;
  logic irq_req, push_stb, per_summary, gdis, wake;
  logic [7:0] vec_addr;
  logic [2:0] core_flags;
  logic [NP-1:0] per_flags;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_vector_ctl #(.NPER(NP), .VEC_W(8)) u0 (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .cnt_pin(cnt_pin), .cnt_rise(cnt_rise), .tmr_ovf(tmr_ovf),
    .per_evt(per_evt), .core_en(core_en), .per_en(per_en),
    .per_grp_en(per_grp_en), .flag_wr(flag_wr), .flag_wr_val(flag_wr_val),
    .per_clr(per_clr), .gdis_wr(gdis_wr), .gdis_val(gdis_val),
    .reti(reti), .ack(ack), .irq_req(irq_req), .vec_addr(vec_addr),
    .push_stb(push_stb), .core_flags(core_flags), .per_flags(per_flags),
    .per_summary(per_summary), .gdis(gdis), .wake(wake)
  );

  // row: force[24:22] tmr[21] pevt[20:17] cen[16:14] pen[13:10] grp[9] req[8] vec[7:0]
  localparam logic [24:0] TBL [NROW] = '{
    {3'b001, 1'b0, 4'h0, 3'b111, 4'h0, 1'b0, 1'b1, 8'h08},
    {3'b010, 1'b0, 4'h0, 3'b111, 4'h0, 1'b0, 1'b1, 8'h10},
    {3'b100, 1'b0, 4'h0, 3'b111, 4'h0, 1'b0, 1'b1, 8'h18},
    {3'b000, 1'b0, 4'h1, 3'b000, 4'h1, 1'b1, 1'b1, 8'h20},
    {3'b111, 1'b0, 4'h0, 3'b111, 4'h0, 1'b0, 1'b1, 8'h08},
    {3'b110, 1'b0, 4'h0, 3'b111, 4'h0, 1'b0, 1'b1, 8'h10},
    {3'b110, 1'b0, 4'h0, 3'b101, 4'h0, 1'b0, 1'b1, 8'h18},
    {3'b000, 1'b0, 4'h4, 3'b111, 4'h3, 1'b1, 1'b0, 8'h00},
    {3'b000, 1'b0, 4'h2, 3'b111, 4'h2, 1'b0, 1'b0, 8'h00},
    {3'b100, 1'b0, 4'h8, 3'b111, 4'h8, 1'b1, 1'b1, 8'h18},
    {3'b000, 1'b1, 4'h0, 3'b010, 4'h0, 1'b0, 1'b1, 8'h10},
    {3'b001, 1'b0, 4'h1, 3'b000, 4'h1, 1'b1, 1'b1, 8'h20}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    tmr_ovf = 0; per_evt = '0; flag_wr = 0; flag_wr_val = '0;
    per_clr = '0; gdis_wr = 0; gdis_val = 0; reti = 0; ack = 0;
  endtask

  task automatic clean();
    tick();
    flag_wr = 1; flag_wr_val = '0; per_clr = '1; gdis_wr = 1; gdis_val = 0;
    tick();
    idle_inputs();
    tick();
  endtask

  task automatic pulse_ack();
    tick(); ack = 1;
    tick(); ack = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1; ext_pin = 0; cnt_pin = 0; ext_rise = 1; cnt_rise = 1;
    core_en = '0; per_en = '0; per_grp_en = 0;
    idle_inputs();
    tick(); tick(); tick();
    // R1: reset state
    chk("R1 irq", irq_req, 0); chk("R1 vec", vec_addr, 0);
    chk("R1 flags", {core_flags, per_flags}, 0);
    chk("R1 misc", {gdis, push_stb, wake, per_summary}, 0);
    rst = 0;

    // R4 R5 R7 table
    for (int r = 0; r < NROW; r++) begin
      core_en = TBL[r][16:14]; per_en = TBL[r][13:10]; per_grp_en = TBL[r][9];
      clean();
      flag_wr = |TBL[r][24:22]; flag_wr_val = TBL[r][24:22];
      tmr_ovf = TBL[r][21]; per_evt = TBL[r][20:17];
      tick();
      idle_inputs();
      tick();
      chk($sformatf("R4 R5 row%0d irq", r), irq_req, TBL[r][8]);
      chk($sformatf("R4 R5 R7 row%0d vec", r), vec_addr, TBL[r][7:0]);
    end

    // R3: pin edge polarity
    core_en = '0; per_en = '0; per_grp_en = 0; ext_rise = 1; cnt_rise = 0;
    clean();
    ext_pin = 1; cnt_pin = 1; tick();
    chk("R3 ext rising sets", core_flags[0], 1);
    chk("R3 cnt rising ignored", core_flags[2], 0);
    clean();
    ext_pin = 0; cnt_pin = 0; tick();
    chk("R3 ext falling ignored", core_flags[0], 0);
    chk("R3 cnt falling sets", core_flags[2], 1);

    // R2 R9 R11: flag set while disabled, wake under disable
    clean();
    tick(); gdis_wr = 1; gdis_val = 1;
    tick(); idle_inputs(); tmr_ovf = 1;
    tick(); tmr_ovf = 0;
    chk("R2 flag set while disabled", core_flags, 3'b010);
    chk("R11 gdis written", gdis, 1);
    tick();
    chk("R9 no wake when enable low", wake, 0);
    core_en = 3'b010;
    tick();
    chk("R9 wake under disable", wake, 1);
    chk("R11 no request under disable", irq_req, 0);

    // R8: return re-raises pending request
    reti = 1; tick(); reti = 0;
    chk("R8 gdis cleared", gdis, 0);
    tick();
    chk("R8 request again", irq_req, 1);
    chk("R8 vector", vec_addr, 8'h10);

    // R6: accept core source
    pulse_ack();
    chk("R6 irq dropped", irq_req, 0);
    chk("R6 gdis set", gdis, 1);
    chk("R6 push pulse", push_stb, 1);
    chk("R6 core flag cleared", core_flags[1], 0);
    tick();
    chk("R6 push one cycle", push_stb, 0);

    // R6: ack without request ignored
    clean();
    pulse_ack();
    chk("R6 idle ack gdis", gdis, 0);
    chk("R6 idle ack push", push_stb, 0);

    // R7: peripheral flag survives acceptance
    core_en = '0; per_en = 4'h1; per_grp_en = 1;
    clean();
    per_evt = 4'h1; tick(); per_evt = '0; tick();
    chk("R7 peripheral vector", vec_addr, 8'h20);
    pulse_ack();
    chk("R7 flag kept after accept", per_flags[0], 1);
    chk("R7 summary kept", per_summary, 1);
    per_clr = 4'h1; tick(); per_clr = '0; tick();
    chk("R7 flag cleared by software", per_flags[0], 0);
    chk("R7 summary cleared", per_summary, 0);

    // R10: event beats clearing write; write 1 forces
    core_en = '0;
    clean();
    flag_wr = 1; flag_wr_val = 3'b000; tmr_ovf = 1;
    tick(); idle_inputs();
    chk("R10 event wins over clear", core_flags[1], 1);
    flag_wr = 1; flag_wr_val = 3'b100;
    tick(); idle_inputs();
    chk("R10 write loads value", core_flags, 3'b100);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule